// File: doc/BRIEF.md
# Dual-Channel DAC Data Controller

This block is the digital front end for a two-channel digital-to-analog converter. Software writes sample data through a simple word-addressed write port. There are three data formats: 12-bit right-justified, 12-bit left-justified and 8-bit. Each format has a register for channel 1, a register for channel 2 and a packed register that loads both channels in one write. Each channel keeps a holding value. That value is copied into the channel's output code either on the next clock or on a trigger pulse. The trigger comes from one of seven external lines or from a self-clearing software strobe.

With DMA enabled, each accepted trigger raises a per-channel request that stays up until it is acknowledged. If a trigger arrives while the request is still up, the channel sets a sticky underrun flag, which software clears by writing one. A disabled channel drives a zero code and ignores triggers. Reads are combinational from a separate read address and return control, status, strobe and output-code words.

Top module: `dacfe_top`

## Requirements
- R1: While reset is asserted, both codes and both DMA requests are 0, and CTRL (address 0) and STAT (address 1) read 0. CTRL holds 6 bits per channel: channel 1 at bits 5:0 and channel 2 at bits 13:8. Within each 6-bit field, bit 0 is enable, bit 1 is trigger enable, bits 4:2 are the source select and bit 5 is DMA enable.
- R2: A disabled channel drives code 0 from the clock after it is disabled. On that channel a trigger raises no DMA request and sets no underrun flag.
- R3: With the channel enabled and trigger enable clear, a write to the 12-bit right-justified register loads bits 11:0 of the data into the code one clock after the write clock. The addresses are 3 for channel 1 and 6 for channel 2.
- R4: A write to the 12-bit left-justified register takes bits 15:4 of the data. The addresses are 4 for channel 1 and 7 for channel 2.
- R5: A write to the 8-bit register places data bits 7:0 in code bits 11:4, with code bits 3:0 zero. The addresses are 5 for channel 1 and 8 for channel 2.
- R6: The packed registers load both channels in one write, in the format of their single-channel counterparts. The addresses are 9 (right), 10 (left) and 11 (8-bit). Channel 1 takes data bits 15:0 and channel 2 takes data bits 31:16.
- R7: With trigger enable set, the code keeps its value until the selected source pulses high at a clock edge, and the holding value appears at that edge. Source codes 0 to 6 select ext_trig bits 0 to 6. Pulses on unselected lines change nothing.
- R8: Source code 7 selects the software strobe, which is set by writing a 1 to bit c-1 of SWTRIG (address 2) for channel c. The code updates one clock after the strobe write, and the strobe reads 0 after that.
- R9: With DMA enable set, an accepted trigger raises dma_req for that channel on the trigger clock. The request stays high until dma_ack is high at a clock edge.
- R10: A trigger accepted while that channel's request is still high and dma_ack is low sets STAT bit c-1 and leaves the request high.
- R11: Writing 1 to a STAT bit clears it, and writing 0 leaves it set. An underrun in the same clock as the clearing write leaves the bit set.
- R12: DOUT1 (address 12) and DOUT2 (address 13) read back the current channel-1 and channel-2 codes in bits 11:0.
- R13: A trigger and dma_ack in the same clock, with a request pending, keep the request high and set no underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 4 | Word address of the combinational read |
| rd_data | output | 32 | Read data |
| ext_trig | input | 7 | Single-cycle external trigger pulses |
| dma_ack | input | 2 | Per-channel DMA acknowledge |
| dma_req | output | 2 | Per-channel DMA request |
| code_ch1 | output | 12 | Channel 1 output code |
| code_ch2 | output | 12 | Channel 2 output code |

## Verification
Request bookkeeping can meet other events in the same clock in two ways. A new trigger can arrive together with the acknowledge of the pending request. An underrun can be set by a trigger in the same clock as a software write-one clear of the flag. The bench drives both pairs in one cycle from the falling edge while a request is pending. It then judges the result one edge later by reading STAT and sampling dma_req: the request must stay high with no underrun in the first case, and the flag must stay set in the second.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
  localparam int NCH         = 2;
  localparam int CODE_W      = 12;
  localparam int BUS_W       = 32;
  localparam int HALF_W      = BUS_W / 2;
  localparam int ADDR_W      = 4;
  localparam int SEL_W       = 3;
  localparam int NEXT        = (1 << SEL_W) - 1;
  localparam int CTRL_STRIDE = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd0;
  localparam logic [ADDR_W-1:0] A_STAT  = 4'd1;
  localparam logic [ADDR_W-1:0] A_SWTRG = 4'd2;
  localparam logic [ADDR_W-1:0] A_R12_1 = 4'd3;
  localparam logic [ADDR_W-1:0] A_L12_1 = 4'd4;
  localparam logic [ADDR_W-1:0] A_R8_1  = 4'd5;
  localparam logic [ADDR_W-1:0] A_R12_2 = 4'd6;
  localparam logic [ADDR_W-1:0] A_L12_2 = 4'd7;
  localparam logic [ADDR_W-1:0] A_R8_2  = 4'd8;
  localparam logic [ADDR_W-1:0] A_R12_D = 4'd9;
  localparam logic [ADDR_W-1:0] A_L12_D = 4'd10;
  localparam logic [ADDR_W-1:0] A_R8_D  = 4'd11;
  localparam logic [ADDR_W-1:0] A_DOUT1 = 4'd12;
  localparam logic [ADDR_W-1:0] A_DOUT2 = 4'd13;

  typedef struct packed {
    logic             dma_en;
    logic [SEL_W-1:0] src;
    logic             trg_en;
    logic             en;
  } chctl_t;

  localparam int CTL_W = $bits(chctl_t);

  typedef enum logic [1:0] {FMT_R12, FMT_L12, FMT_R8} fmt_e;

  function automatic logic [CODE_W-1:0] justify(fmt_e f, logic [HALF_W-1:0] hw);
    case (f)
      FMT_L12: justify = hw[HALF_W-1 -: CODE_W];
      FMT_R8:  justify = {hw[7:0], {(CODE_W-8){1'b0}}};
      default: justify = hw[CODE_W-1:0];
    endcase
  endfunction
endpackage

// File: rtl/dacfe_regs.sv
module dacfe_regs
  import dacfe_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BUS_W-1:0]        wr_data,
  output chctl_t                  ctl     [NCH],
  output logic [NCH-1:0]          ld,
  output logic [CODE_W-1:0]       ld_val  [NCH],
  output logic [NCH-1:0]          sw_trig,
  output logic [NCH-1:0]          udr_clr
);
  fmt_e           fmt;
  logic [NCH-1:0] mask;
  logic           dual;
  chctl_t         ctl_d [NCH];
  chctl_t         ctl_q [NCH];
  logic [NCH-1:0] sw_d, sw_q;

  always_comb begin
    fmt  = FMT_R12;
    mask = '0;
    dual = 1'b0;
    case (wr_addr)
      A_R12_1: begin fmt = FMT_R12; mask = 2'b01; end
      A_L12_1: begin fmt = FMT_L12; mask = 2'b01; end
      A_R8_1:  begin fmt = FMT_R8;  mask = 2'b01; end
      A_R12_2: begin fmt = FMT_R12; mask = 2'b10; end
      A_L12_2: begin fmt = FMT_L12; mask = 2'b10; end
      A_R8_2:  begin fmt = FMT_R8;  mask = 2'b10; end
      A_R12_D: begin fmt = FMT_R12; mask = 2'b11; dual = 1'b1; end
      A_L12_D: begin fmt = FMT_L12; mask = 2'b11; dual = 1'b1; end
      A_R8_D:  begin fmt = FMT_R8;  mask = 2'b11; dual = 1'b1; end
      default: ;
    endcase
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ld[c]      = wr_en & mask[c];
    assign ld_val[c]  = justify(fmt, dual ? wr_data[HALF_W*c +: HALF_W] : wr_data[HALF_W-1:0]);
    assign udr_clr[c] = wr_en & (wr_addr == A_STAT) & wr_data[c];

    always_comb begin
      ctl_d[c] = ctl_q[c];
      if (wr_en && wr_addr == A_CTRL)
        ctl_d[c] = wr_data[CTRL_STRIDE*c +: CTL_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctl_q[c] <= '0;
      else        ctl_q[c] <= ctl_d[c];
    end

    assign ctl[c] = ctl_q[c];
  end

  always_comb begin
    sw_d = '0;
    if (wr_en && wr_addr == A_SWTRG) sw_d = wr_data[NCH-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= '0;
    else        sw_q <= sw_d;
  end

  assign sw_trig = sw_q;

  AST_SW_SELFCLR: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && wr_addr == A_SWTRG) |=> (sw_q == '0)); // R8
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  chctl_t            ctl,
  input  logic [NEXT-1:0]   ext_trig,
  input  logic              sw_trig,
  input  logic              ld,
  input  logic [CODE_W-1:0] ld_val,
  input  logic              dma_ack,
  input  logic              udr_clr,
  output logic [CODE_W-1:0] dout,
  output logic              dma_req,
  output logic              udr
);
  logic [NEXT:0]       src_vec;
  logic                fire;
  logic [CODE_W-1:0]   hold_d, hold_q, dout_d, dout_q;
  logic                req_d, req_q, udr_d, udr_q;

  assign src_vec = {sw_trig, ext_trig};
  assign fire    = ctl.en & ctl.trg_en & src_vec[ctl.src];

  always_comb begin
    hold_d = ld ? ld_val : hold_q;

    if (!ctl.en)                 dout_d = '0;
    else if (!ctl.trg_en || fire) dout_d = hold_q;
    else                          dout_d = dout_q;

    if (!ctl.en)                  req_d = 1'b0;
    else if (fire && ctl.dma_en)  req_d = 1'b1;
    else if (dma_ack)             req_d = 1'b0;
    else                          req_d = req_q;

    if (fire && ctl.dma_en && req_q && !dma_ack) udr_d = 1'b1;
    else if (udr_clr)                             udr_d = 1'b0;
    else                                          udr_d = udr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      dout_q <= '0;
      req_q  <= 1'b0;
      udr_q  <= 1'b0;
    end else begin
      hold_q <= hold_d;
      dout_q <= dout_d;
      req_q  <= req_d;
      udr_q  <= udr_d;
    end
  end

  assign dout    = dout_q;
  assign dma_req = req_q;
  assign udr     = udr_q;

  AST_DIS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.en |=> (dout_q == '0)); // R2
  AST_NOTRIG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.en && ctl.trg_en && !src_vec[ctl.src]) |=> $stable(dout_q)); // R7
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_q && ctl.en && !dma_ack) |=> req_q); // R9
  AST_UDR_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl.dma_en && req_q && !dma_ack) |=> (udr_q && req_q)); // R10
  AST_UDR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (udr_q && !udr_clr) |=> udr_q); // R11
  AST_ACK_TRIG: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && ctl.dma_en && req_q && dma_ack && !udr_q) |=> (req_q && !udr_q)); // R13
endmodule

// File: rtl/dacfe_top.sv
module dacfe_top
  import dacfe_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [3:0]        rd_addr,
  output logic [31:0]       rd_data,
  input  logic [6:0]        ext_trig,
  input  logic [1:0]        dma_ack,
  output logic [1:0]        dma_req,
  output logic [11:0]       code_ch1,
  output logic [11:0]       code_ch2
);
  logic [1:0]        rst_sync;
  logic              rst_in_n;
  chctl_t            ctl     [NCH];
  logic [NCH-1:0]    ld, sw_trig, udr_clr, udr;
  logic [CODE_W-1:0] ld_val  [NCH];
  logic [CODE_W-1:0] dout    [NCH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_in_n = rst_sync[1];

  dacfe_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_in_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .ctl     (ctl),
    .ld      (ld),
    .ld_val  (ld_val),
    .sw_trig (sw_trig),
    .udr_clr (udr_clr)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    dacfe_chan u_chan (
      .clk      (clk),
      .rst_n    (rst_in_n),
      .ctl      (ctl[c]),
      .ext_trig (ext_trig),
      .sw_trig  (sw_trig[c]),
      .ld       (ld[c]),
      .ld_val   (ld_val[c]),
      .dma_ack  (dma_ack[c]),
      .udr_clr  (udr_clr[c]),
      .dout     (dout[c]),
      .dma_req  (dma_req[c]),
      .udr      (udr[c])
    );
  end

  assign code_ch1 = dout[0];
  assign code_ch2 = dout[1];

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      A_CTRL:  for (int c = 0; c < NCH; c++) rd_data[CTRL_STRIDE*c +: CTL_W] = ctl[c];
      A_STAT:  rd_data[NCH-1:0] = udr;
      A_SWTRG: rd_data[NCH-1:0] = sw_trig;
      A_DOUT1: rd_data[CODE_W-1:0] = dout[0];
      A_DOUT2: rd_data[CODE_W-1:0] = dout[1];
      default: ;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_in_n |-> (dma_req == '0 && code_ch1 == '0 && code_ch2 == '0)); // R1
endmodule

// File: tb/dacfe_top_bench.sv
module dacfe_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 9;
  // {addr, data, expected ch1 code, expected ch2 code}
  localparam logic [59:0] VEC [NVEC] = '{
    {4'd3,  32'hFFFF_FABC, 12'hABC, 12'h000},
    {4'd4,  32'h0000_1234, 12'h123, 12'h000},
    {4'd5,  32'h0000_12C5, 12'hC50, 12'h000},
    {4'd6,  32'h0000_0777, 12'hC50, 12'h777},
    {4'd7,  32'h0000_FEDC, 12'hC50, 12'hFED},
    {4'd8,  32'h0000_003A, 12'hC50, 12'h3A0},
    {4'd9,  32'h0456_0321, 12'h321, 12'h456},
    {4'd10, 32'hABCD_1234, 12'h123, 12'hABC},
    {4'd11, 32'h0099_0011, 12'h110, 12'h990}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [3:0]  wr_addr, rd_addr;
  logic [31:0] wr_data, rd_data;
  logic [6:0]  ext_trig;
  logic [1:0]  dma_ack, dma_req;
  logic [11:0] code_ch1, code_ch2;
  int          n_chk = 0, n_err = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dacfe_top u_dacfe_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .ext_trig(ext_trig), .dma_ack(dma_ack),
    .dma_req(dma_req), .code_ch1(code_ch1), .code_ch2(code_ch2)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(logic [6:0] t, logic [1:0] ack);
    @(negedge clk);
    ext_trig = t; dma_ack = ack;
    @(negedge clk);
    ext_trig = '0; dma_ack = '0;
  endtask

  task automatic rd_chk(string tag, logic [3:0] a, logic [31:0] exp);
    rd_addr = a;
    #1;
    chk(tag, rd_data, exp);
  endtask

  function automatic string tag_of(logic [3:0] a);
    case (a)
      4'd3, 4'd6: tag_of = "R3";
      4'd4, 4'd7: tag_of = "R4";
      4'd5, 4'd8: tag_of = "R5";
      default:    tag_of = "R6";
    endcase
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    rd_addr = '0; ext_trig = '0; dma_ack = '0;
    repeat (3) tick();
    chk("R1 code1", {20'd0, code_ch1}, 32'd0);
    chk("R1 code2", {20'd0, code_ch2}, 32'd0);
    chk("R1 req", {30'd0, dma_req}, 32'd0);
    rd_chk("R1 ctrl", 4'd0, 32'd0);
    rd_chk("R1 stat", 4'd1, 32'd0);
    rst_n = 1'b1;
    repeat (3) tick();

    // Table: both channels enabled, trigger disabled
    wr(4'd0, 32'h0000_0101);
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][59:56], VEC[i][55:24]);
      tick();
      chk({tag_of(VEC[i][59:56]), " code1"}, {20'd0, code_ch1}, {20'd0, VEC[i][23:12]});
      chk({tag_of(VEC[i][59:56]), " code2"}, {20'd0, code_ch2}, {20'd0, VEC[i][11:0]});
      rd_chk("R12 dout1", 4'd12, {20'd0, VEC[i][23:12]});
      rd_chk("R12 dout2", 4'd13, {20'd0, VEC[i][11:0]});
    end

    // DMA: ch1 en|trg|src0|dma, ch2 disabled with trg|dma
    wr(4'd0, 32'h0000_2223);
    rd_chk("R1 ctrl readback", 4'd0, 32'h0000_2223);
    tick();
    chk("R2 disabled code2", {20'd0, code_ch2}, 32'd0);
    pulse(7'h01, 2'b00);
    chk("R9 req raised", {30'd0, dma_req}, 32'd1);
    chk("R7 trig moves code1", {20'd0, code_ch1}, 32'h110);
    chk("R2 disabled ch2 no req", {31'd0, dma_req[1]}, 32'd0);
    rd_chk("R2 no udr ch2", 4'd1, 32'd0);
    pulse(7'h01, 2'b00);
    rd_chk("R10 udr set", 4'd1, 32'd1);
    chk("R10 req kept", {30'd0, dma_req}, 32'd1);
    wr(4'd1, 32'h0000_0000);
    rd_chk("R11 write0 no effect", 4'd1, 32'd1);
    wr(4'd1, 32'h0000_0001);
    rd_chk("R11 write1 clears", 4'd1, 32'd0);
    pulse(7'h01, 2'b01);
    chk("R13 req stays", {30'd0, dma_req}, 32'd1);
    rd_chk("R13 no udr", 4'd1, 32'd0);
    // underrun and clear in the same clock
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'd1; wr_data = 32'h1; ext_trig = 7'h01;
    @(negedge clk);
    wr_en = 1'b0; ext_trig = '0;
    rd_chk("R11 set wins", 4'd1, 32'd1);
    pulse(7'h00, 2'b01);
    chk("R9 ack drops req", {30'd0, dma_req}, 32'd0);
    wr(4'd1, 32'h0000_0001);

    // Source select: ch1 src3, ch2 software
    wr(4'd0, 32'h0000_1F0F);
    wr(4'd3, 32'h0000_05A5);
    tick();
    chk("R7 waits for trigger", {20'd0, code_ch1}, 32'h110);
    pulse(7'h04, 2'b00);
    chk("R7 other line ignored", {20'd0, code_ch1}, 32'h110);
    pulse(7'h08, 2'b00);
    chk("R7 selected line", {20'd0, code_ch1}, 32'h5A5);
    wr(4'd6, 32'h0000_02B2);
    pulse(7'h7F, 2'b00);
    chk("R8 ext lines ignored", {20'd0, code_ch2}, 32'd0);
    wr(4'd2, 32'h0000_0002);
    chk("R8 one clock latency", {20'd0, code_ch2}, 32'd0);
    tick();
    chk("R8 sw trigger", {20'd0, code_ch2}, 32'h2B2);
    rd_chk("R8 strobe self-clears", 4'd2, 32'd0);

    // Asynchronous reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset code1", {20'd0, code_ch1}, 32'd0);
    rd_chk("R1 async reset ctrl", 4'd0, 32'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule